// File: doc/BRIEF.md
# Serial Display Link Transmitter

This block is the host-side sender for a write-only serial link to a display controller. Bytes arrive on a valid/ready input, each tagged as either a command or a data byte. The block frames them with an active-low chip select, shifts each one out most significant bit first on a serial clock and data pair, and holds a command/data select line at the byte's tag for the whole byte. The receiving side samples on the rising serial clock edge. The serial clock idles low, and the data line changes only on falling edges.

Before any transfer, the block drives an active-low reset pulse to the display. It does this after its own reset and again whenever `reset_req` is raised. A settle interval follows the pulse, and the input stays closed until it ends. All link timing comes from the system clock through cycle-count parameters. An elaboration-time check compares each count against its nanosecond minimum at the configured clock frequency: half period 50 ns, full period 80 ns, select lead and lag 40 ns, reset width 2000 ns.

If another byte is offered within a short window after a byte finishes, it goes out under the same chip-select assertion. If not, chip select is released.

Top module: `disp_link_tx`

## Requirements
- R1: During the reset pulse, `disp_res_n` is 0 and `in_ready` is 0. After `rst_n` is deasserted, the pulse lasts at least `RST_CYC` clock cycles.
- R2: After `disp_res_n` rises, `in_ready` stays 0 for exactly `SETTLE_CYC` cycles and is 1 in the cycle after that.
- R3: `in_ready` is 0 whenever `disp_sclk` is high, so no byte is accepted while one is being shifted.
- R4: Each accepted byte produces exactly eight rising `disp_sclk` edges, all with `disp_cs_n` = 0. The `disp_sdin` values sampled at those edges are the byte, bit 7 first.
- R5: At every rising edge of a byte, `disp_dc` equals the `in_is_data` flag that was latched when the byte was accepted (1 = data, 0 = command).
- R6: Every high phase and every low phase of `disp_sclk` lasts at least `HALF_CYC` cycles.
- R7: `disp_sdin` and `disp_dc` stay constant while `disp_sclk` is high. Before each rising edge, both have held their value for more than `HALF_CYC` cycles.
- R8: `disp_cs_n` falls at least `CS_LEAD + HALF_CYC` cycles before the first rising edge of a transfer. It rises at least `HALF_CYC + CS_LAG` cycles after the last rising edge.
- R9: Bytes offered back to back, with `in_valid` held high, share one chip-select assertion. A byte sent after the link has gone idle gets its own assertion.
- R10: A cycle with `reset_req` = 1 starts a new reset pulse of exactly `RST_CYC` cycles in the next cycle and abandons any byte in flight. Transfers resume normally after the settle interval.
- R11: While `disp_res_n` is 0, `disp_cs_n` is 1 and `disp_sclk` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| reset_req | input | 1 | Request a new display reset pulse |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_is_data | input | 1 | 1 = data byte, 0 = command byte |
| in_ready | output | 1 | Block can accept a byte this cycle |
| disp_res_n | output | 1 | Active-low display reset |
| disp_cs_n | output | 1 | Active-low chip select |
| disp_sclk | output | 1 | Serial clock, idles low |
| disp_sdin | output | 1 | Serial data, MSB first |
| disp_dc | output | 1 | Command/data select for the current byte |

## Verification
A byte accepted at a clock edge pulls `disp_cs_n` low at that same edge. Its first rising serial edge follows `CS_LEAD + HALF_CYC` cycles later, and each further bit follows `2*HALF_CYC` cycles after the one before. `disp_res_n` goes low one edge after `reset_req` is seen, and `in_ready` returns exactly `SETTLE_CYC` cycles after `disp_res_n` rises. The bench samples all outputs on the falling system clock edge and measures every interval as a count of those samples. Each check is made on the sample where the serial clock, chip select or reset output has just changed level, so a check never has to guess the cycle on which a result will appear.

// File: rtl/disp_link_tx.sv
module disp_link_tx #(
  parameter int CLK_MHZ    = 50,
  parameter int HALF_CYC   = 3,
  parameter int CS_LEAD    = 2,
  parameter int CS_LAG     = 2,
  parameter int RST_CYC    = 100,
  parameter int SETTLE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reset_req,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_is_data,
  output logic       in_ready,
  output logic       disp_res_n,
  output logic       disp_cs_n,
  output logic       disp_sclk,
  output logic       disp_sdin,
  output logic       disp_dc
);

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int ns_of(input int c);
    return c * 1000 / CLK_MHZ;
  endfunction

  localparam int MAXC = mx(mx(RST_CYC, SETTLE_CYC), mx(HALF_CYC, mx(CS_LEAD, CS_LAG)));
  localparam int CW   = $clog2(MAXC + 1);

  generate
    if (ns_of(HALF_CYC) < 50 || ns_of(2 * HALF_CYC) < 80)
      begin : g_bad_half
        $error("HALF_CYC too short for serial clock phase or period");
      end
    if (CS_LEAD < 1 || ns_of(CS_LEAD + HALF_CYC) < 40)
      begin : g_bad_lead
        $error("CS_LEAD too short for chip select setup");
      end
    if (CS_LAG < 1 || ns_of(CS_LAG + HALF_CYC) < 40)
      begin : g_bad_lag
        $error("CS_LAG too short for chip select hold");
      end
    if (ns_of(RST_CYC) < 2000 || SETTLE_CYC < 1)
      begin : g_bad_rst
        $error("RST_CYC or SETTLE_CYC out of range");
      end
  endgenerate

  typedef enum logic [2:0] {
    S_RST, S_SETTLE, S_IDLE, S_LEAD, S_LOW, S_HIGH, S_TAIL
  } st_t;

  function automatic logic [CW-1:0] ld(input int n);
    return CW'(n - 1);
  endfunction

  st_t           st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [2:0]    bit_q, bit_n;
  logic [7:0]    sh, sh_n;
  logic          dc_q, dc_n;
  logic          sclk_q, cs_q, res_q;

  wire last = (cnt == '0);
  assign in_ready = (st == S_IDLE || st == S_TAIL) && !reset_req;
  wire take = in_valid && in_ready;

  always_comb begin
    st_n  = st;
    cnt_n = last ? cnt : cnt - 1'b1;
    bit_n = bit_q;
    sh_n  = sh;
    dc_n  = dc_q;
    if (reset_req) begin
      st_n  = S_RST;
      cnt_n = ld(RST_CYC);
    end else begin
      case (st)
        S_RST:
          if (last) begin
            st_n  = S_SETTLE;
            cnt_n = ld(SETTLE_CYC);
          end
        S_SETTLE:
          if (last) st_n = S_IDLE;
        S_IDLE:
          if (take) begin
            st_n  = S_LEAD;
            cnt_n = ld(CS_LEAD);
            sh_n  = in_data;
            dc_n  = in_is_data;
            bit_n = '0;
          end
        S_LEAD:
          if (last) begin
            st_n  = S_LOW;
            cnt_n = ld(HALF_CYC);
          end
        S_LOW:
          if (last) begin
            st_n  = S_HIGH;
            cnt_n = ld(HALF_CYC);
          end
        S_HIGH:
          if (last) begin
            if (bit_q == 3'd7) begin
              st_n  = S_TAIL;
              cnt_n = ld(CS_LAG);
            end else begin
              st_n  = S_LOW;
              cnt_n = ld(HALF_CYC);
              sh_n  = {sh[6:0], 1'b0};
              bit_n = bit_q + 3'd1;
            end
          end
        S_TAIL:
          if (take) begin
            st_n  = S_LOW;
            cnt_n = ld(HALF_CYC);
            sh_n  = in_data;
            dc_n  = in_is_data;
            bit_n = '0;
          end else if (last) begin
            st_n = S_IDLE;
          end
        default: st_n = S_RST;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_RST;
      cnt    <= ld(RST_CYC);
      bit_q  <= '0;
      sh     <= '0;
      dc_q   <= 1'b0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      res_q  <= 1'b0;
    end else begin
      st     <= st_n;
      cnt    <= cnt_n;
      bit_q  <= bit_n;
      sh     <= sh_n;
      dc_q   <= dc_n;
      sclk_q <= (st_n == S_HIGH);
      cs_q   <= !(st_n inside {S_LEAD, S_LOW, S_HIGH, S_TAIL});
      res_q  <= (st_n != S_RST);
    end
  end

  assign disp_res_n = res_q;
  assign disp_cs_n  = cs_q;
  assign disp_sclk  = sclk_q;
  assign disp_sdin  = sh[7];
  assign disp_dc    = dc_q;

endmodule

// File: rtl/disp_link_tx_chk.sv
module disp_link_tx_chk #(
  parameter int HALF_CYC = 3
) (
  input logic clk,
  input logic rst_n,
  input logic reset_req,
  input logic in_ready,
  input logic disp_res_n,
  input logic disp_cs_n,
  input logic disp_sclk,
  input logic disp_sdin,
  input logic disp_dc
);

  int hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= 0;
    else        hi_run <= disp_sclk ? hi_run + 1 : 0;
  end

  // R11
  quiet_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_res_n |-> (disp_cs_n && !disp_sclk));

  // R3
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_sclk |-> !in_ready);

  // R7
  hold_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_sclk |-> ($stable(disp_sdin) && $stable(disp_dc)));

  // R4
  sclk_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_sclk |-> !disp_cs_n);

  // R10
  req_pulls_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !disp_res_n);

  // R6
  high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(disp_sclk) |-> (hi_run >= HALF_CYC));

endmodule

bind disp_link_tx disp_link_tx_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .in_ready(in_ready),
  .disp_res_n(disp_res_n), .disp_cs_n(disp_cs_n), .disp_sclk(disp_sclk),
  .disp_sdin(disp_sdin), .disp_dc(disp_dc)
);

// File: tb/test_disp_link_tx.sv
module test_disp_link_tx;
  localparam int HALF = 3, LEAD = 2, LAG = 2, RSTW = 100, SETTLE = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, reset_req = 1'b0, in_valid = 1'b0, in_is_data = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, disp_res_n, disp_cs_n, disp_sclk, disp_sdin, disp_dc;

  disp_link_tx #(.CLK_MHZ(50), .HALF_CYC(HALF), .CS_LEAD(LEAD), .CS_LAG(LAG),
                 .RST_CYC(RSTW), .SETTLE_CYC(SETTLE)) i_disp_link_tx (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .in_valid(in_valid),
    .in_data(in_data), .in_is_data(in_is_data), .in_ready(in_ready),
    .disp_res_n(disp_res_n), .disp_cs_n(disp_cs_n), .disp_sclk(disp_sclk),
    .disp_sdin(disp_sdin), .disp_dc(disp_dc));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [8:0] tag(input logic [7:0] b, input logic d);
    return {d, b};
  endfunction

  logic [8:0] expq[$];

  bit   mon_on = 0, req_pulse = 0;
  logic p_sclk = 0, p_cs = 1, p_res = 0, p_sdin = 0, p_dc = 0;
  int   cyc = 0, lo_run = 0, hi_run = 0, d_age = 0, res_low = 0, since_res = 1000;
  int   cs_fall_t = 0, last_rise_t = 0, rx_bits = 0, cs_falls = 0;
  logic [7:0] rx = '0;
  logic rx_dc = 0;

  always @(negedge clk) if (mon_on) begin
    cyc++;
    if (disp_sdin !== p_sdin || disp_dc !== p_dc) d_age = 1; else d_age++;
    if (!disp_res_n) begin
      res_low++;
      chk(disp_cs_n && !disp_sclk, "R11", {disp_cs_n, disp_sclk}, 2);
      chk(!in_ready, "R1", in_ready, 0);
      rx_bits = 0;
    end
    if (disp_res_n && !p_res) begin
      if (req_pulse) chk(res_low == RSTW, "R10", res_low, RSTW);
      else           chk(res_low >= RSTW, "R1", res_low, RSTW);
      req_pulse = 0;
      res_low   = 0;
      since_res = 0;
    end
    if (disp_res_n && since_res <= SETTLE) begin
      since_res++;
      if (since_res <= SETTLE) chk(!in_ready, "R2", in_ready, 0);
      else                     chk(in_ready, "R2", in_ready, 1);
    end
    if (disp_sclk) chk(!in_ready, "R3", in_ready, 0);
    if (disp_sclk && p_sclk)
      chk(disp_sdin === p_sdin && disp_dc === p_dc, "R7", {disp_sdin, disp_dc}, {p_sdin, p_dc});
    if (!disp_cs_n && p_cs) begin
      cs_fall_t = cyc;
      cs_falls++;
    end
    if (disp_cs_n && !p_cs && disp_res_n)
      chk(cyc - last_rise_t >= HALF + LAG, "R8", cyc - last_rise_t, HALF + LAG);
    if (disp_sclk && !p_sclk) begin
      chk(!disp_cs_n, "R4", disp_cs_n, 0);
      chk(lo_run >= HALF, "R6", lo_run, HALF);
      chk(d_age > HALF, "R7", d_age, HALF + 1);
      if (rx_bits == 0)
        chk(cyc - cs_fall_t >= LEAD + HALF, "R8", cyc - cs_fall_t, LEAD + HALF);
      rx = {rx[6:0], disp_sdin};
      if (rx_bits == 0) rx_dc = disp_dc;
      else if (disp_dc !== rx_dc) chk(0, "R5", disp_dc, rx_dc);
      rx_bits++;
      last_rise_t = cyc;
      if (rx_bits == 8) begin
        rx_bits = 0;
        if (expq.size() == 0) chk(0, "R4", rx, -1);
        else begin
          logic [8:0] e;
          e = expq.pop_front();
          chk(rx == e[7:0], "R4", rx, e[7:0]);
          chk(rx_dc == e[8], "R5", rx_dc, e[8]);
        end
      end
    end
    if (!disp_sclk && p_sclk) chk(hi_run >= HALF, "R6", hi_run, HALF);
    if (disp_sclk) begin hi_run = p_sclk ? hi_run + 1 : 1; lo_run = 0; end
    else           begin lo_run = p_sclk ? 1 : lo_run + 1; hi_run = 0; end
    p_sclk = disp_sclk; p_cs = disp_cs_n; p_res = disp_res_n;
    p_sdin = disp_sdin; p_dc = disp_dc;
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_fail++;
      $display("FAIL R4 watchdog: actual %0d expected %0d", wd, 150000);
      finish_run();
    end
  end

  task automatic send(input logic [7:0] b, input logic d, input bit last);
    in_valid   = 1'b1;
    in_data    = b;
    in_is_data = d;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    expq.push_back(tag(b, d));
    @(negedge clk);
    if (last) in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!(disp_cs_n && expq.size() == 0 && rx_bits == 0)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic burst(input int n, input bit rnd, input logic [7:0] b0, input logic d0);
    int f0;
    f0 = cs_falls;
    for (int i = 0; i < n; i++) begin
      if (rnd) send(8'($urandom), 1'($urandom), i == n - 1);
      else     send(b0 ^ 8'(i), d0, i == n - 1);
    end
    wait_idle();
    chk(cs_falls - f0 == 1, "R9", cs_falls - f0, 1);
    chk(expq.size() == 0, "R4", expq.size(), 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    @(posedge clk);
    @(negedge clk);
    mon_on = 1;
    chk(disp_res_n == 0, "R1", disp_res_n, 0);
    chk(disp_cs_n == 1 && disp_sclk == 0, "R11", {disp_cs_n, disp_sclk}, 2);
    chk(in_ready == 0, "R1", in_ready, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    while (!in_ready) @(negedge clk);

    burst(1, 0, 8'h80, 1'b0);
    burst(1, 0, 8'h01, 1'b1);
    burst(1, 0, 8'hFF, 1'b1);
    burst(1, 0, 8'h00, 1'b0);
    burst(4, 0, 8'hA5, 1'b1);
    burst(3, 0, 8'h3C, 1'b0);

    begin
      int f0;
      f0 = cs_falls;
      burst(1, 0, 8'h11, 1'b0);
      repeat (10) @(negedge clk);
      burst(1, 0, 8'h22, 1'b1);
      chk(cs_falls - f0 == 2, "R9", cs_falls - f0, 2);
    end

    send(8'hC3, 1'b1, 1'b1);
    repeat (20) @(negedge clk);
    reset_req = 1'b1;
    req_pulse = 1;
    @(negedge clk);
    reset_req = 1'b0;
    expq.delete();
    chk(disp_res_n == 0, "R10", disp_res_n, 0);
    while (!in_ready) @(negedge clk);
    burst(2, 0, 8'h96, 1'b0);

    reset_req = 1'b1;
    req_pulse = 1;
    @(negedge clk);
    reset_req = 1'b0;
    chk(disp_res_n == 0 && disp_cs_n == 1, "R10", {disp_res_n, disp_cs_n}, 1);
    while (!in_ready) @(negedge clk);

    for (int k = 0; k < 60; k++) begin
      burst(1 + int'($urandom % 4), 1, 8'h00, 1'b0);
      repeat ($urandom % 12) @(negedge clk);
    end

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule